// File: doc/BRIEF.md
# Wiper Position Register with Step Mode

This block holds the tap position of a digitally controlled resistor divider and turns that position into a tap-select bus with one switch closed. The position is a small volatile register that can be set from four sources: a one-time recall of a stored value once the supplies are reported good, a direct write from the serial bus slave, a parallel transfer from a selected stored register, and single-segment steps up or down issued while the bus is in step mode.

When several sources act in the same cycle, a fixed order of precedence decides which one wins. Steps stop at the ends of the range rather than wrapping. The tap-select bus is registered and follows the position one clock later. Bit 0 of that bus closes the switch at the low terminal, and the top bit closes the switch at the high terminal.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `pos` is 0 and `tap_sel` has only bit 0 set.
- R2: On the first rising clock edge after reset where `supply_ok` is high, `pos` takes `recall_val`. This recall happens once per reset. Later toggles of `supply_ok` have no effect on `pos`.
- R3: A cycle with `ser_ld` high and no recall loads `ser_val` into `pos` at that clock edge.
- R4: A cycle with `par_ld` high, `ser_ld` low and no recall loads `par_val` into `pos` at that clock edge.
- R5: In a cycle with no load, `step_up` alone raises `pos` by one and `step_dn` alone lowers `pos` by one.
- R6: A step up at the maximum code (63) leaves `pos` unchanged. A step down at code 0 leaves `pos` unchanged. Neither case wraps.
- R7: A cycle with `step_up` and `step_dn` both high and no load leaves `pos` unchanged. A cycle with no source active also leaves `pos` unchanged.
- R8: When sources coincide, precedence from highest to lowest is: recall, serial load, parallel load, step. The losing sources in that cycle are ignored.
- R9: `tap_sel` always has exactly one bit set. One cycle after `pos` holds value p, that bit is bit p, where bit 0 is the low terminal and bit 63 is the high terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supplies stable; arms the one-time recall |
| recall_val | input | 6 | Stored value recalled at power-up |
| ser_ld | input | 1 | Serial write strobe |
| ser_val | input | 6 | Serial write value |
| par_ld | input | 1 | Parallel transfer strobe |
| par_val | input | 6 | Value from the selected stored register |
| step_up | input | 1 | One-segment step toward the high terminal |
| step_dn | input | 1 | One-segment step toward the low terminal |
| pos | output | 6 | Current position, for read-back |
| tap_sel | output | 64 | Registered one-hot tap switch select |

## Verification
Any two load sources can land in the same cycle. The pairings that matter are a recall against a serial write, a serial write against a parallel transfer, and a parallel transfer against a step. Each pairing is provoked by raising both strobes in one cycle with different values. The position is then compared with the value of the source that should win. Opposite steps in the same cycle are also driven together, and the position must stay put. Saturation is judged by stepping past each end and checking that the code stays at the end.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_SER    = 3'd2,
    SRC_PAR    = 3'd3,
    SRC_STEP   = 3'd4
  } wpc_src_e;
endpackage

// File: rtl/wpc_recall_gate.sv
// Issues one recall pulse on the first supply-good cycle after reset.
module wpc_recall_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic recall_fire
);
  logic done_q;

  assign recall_fire = supply_ok & ~done_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           done_q <= 1'b0;
    else if (recall_fire) done_q <= 1'b1;
  end
endmodule

// File: rtl/wpc_next_pos.sv
// Picks the winning source and computes the next position.
module wpc_next_pos
  import wpc_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic [POS_W-1:0] cur_pos,
  input  logic             recall_fire,
  input  logic [POS_W-1:0] recall_val,
  input  logic             ser_ld,
  input  logic [POS_W-1:0] ser_val,
  input  logic             par_ld,
  input  logic [POS_W-1:0] par_val,
  input  logic             step_up,
  input  logic             step_dn,
  output wpc_src_e         src,
  output logic [POS_W-1:0] nxt_pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  function automatic logic [POS_W-1:0] sat_step(
    input logic [POS_W-1:0] p,
    input logic             up,
    input logic             dn
  );
    if (up && !dn && p != POS_MAX) return p + 1'b1;
    if (dn && !up && p != '0)      return p - 1'b1;
    return p;
  endfunction

  always_comb begin
    if (recall_fire) begin
      src     = SRC_RECALL;
      nxt_pos = recall_val;
    end else if (ser_ld) begin
      src     = SRC_SER;
      nxt_pos = ser_val;
    end else if (par_ld) begin
      src     = SRC_PAR;
      nxt_pos = par_val;
    end else if (step_up || step_dn) begin
      src     = SRC_STEP;
      nxt_pos = sat_step(cur_pos, step_up, step_dn);
    end else begin
      src     = SRC_NONE;
      nxt_pos = cur_pos;
    end
  end
endmodule

// File: rtl/wpc_tap_decode.sv
// Registered one-of-N decode of the position.
module wpc_tap_decode #(
  parameter int POS_W = 6,
  localparam int NUM_TAPS = 1 << POS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] tap_sel
);
  logic [NUM_TAPS-1:0] hot;

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    assign hot[gi] = (pos == POS_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tap_sel <= NUM_TAPS'(1);
    else        tap_sel <= hot;
  end
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
  import wpc_pkg::*;
#(
  parameter int POS_W = 6,
  localparam int NUM_TAPS = 1 << POS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                supply_ok,
  input  logic [POS_W-1:0]    recall_val,
  input  logic                ser_ld,
  input  logic [POS_W-1:0]    ser_val,
  input  logic                par_ld,
  input  logic [POS_W-1:0]    par_val,
  input  logic                step_up,
  input  logic                step_dn,
  output logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] tap_sel
);
  logic             recall_fire;
  wpc_src_e         src;
  logic [POS_W-1:0] nxt_pos;
  logic [POS_W-1:0] pos_q;

  wpc_recall_gate u_recall (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .recall_fire (recall_fire)
  );

  wpc_next_pos #(.POS_W(POS_W)) u_next (
    .cur_pos     (pos_q),
    .recall_fire (recall_fire),
    .recall_val  (recall_val),
    .ser_ld      (ser_ld),
    .ser_val     (ser_val),
    .par_ld      (par_ld),
    .par_val     (par_val),
    .step_up     (step_up),
    .step_dn     (step_dn),
    .src         (src),
    .nxt_pos     (nxt_pos)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= nxt_pos;
  end

  assign pos = pos_q;

  wpc_tap_decode #(.POS_W(POS_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .pos     (pos_q),
    .tap_sel (tap_sel)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker
  import wpc_pkg::*;
#(
  parameter int POS_W = 6,
  localparam int NUM_TAPS = 1 << POS_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                recall_fire,
  input wpc_src_e            src,
  input logic [POS_W-1:0]    recall_val,
  input logic                ser_ld,
  input logic [POS_W-1:0]    ser_val,
  input logic                par_ld,
  input logic [POS_W-1:0]    par_val,
  input logic                step_up,
  input logic                step_dn,
  input logic [POS_W-1:0]    pos,
  input logic [NUM_TAPS-1:0] tap_sel
);
  localparam logic [POS_W-1:0] PMAX = {POS_W{1'b1}};
  logic no_load;
  assign no_load = !recall_fire && !ser_ld && !par_ld;

  a_r2_recall_load: assert property (@(posedge clk) disable iff (!rst_n)
    recall_fire |=> pos == $past(recall_val));

  a_r2_recall_once: assert property (@(posedge clk) disable iff (!rst_n)
    recall_fire |=> !recall_fire);

  a_r3_ser_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ld && !recall_fire) |=> pos == $past(ser_val));

  a_r4_par_load: assert property (@(posedge clk) disable iff (!rst_n)
    (par_ld && !ser_ld && !recall_fire) |=> pos == $past(par_val));

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && step_up && !step_dn && pos != PMAX) |=> pos == $past(pos) + 1'b1);

  a_r5_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && step_dn && !step_up && pos != '0) |=> pos == $past(pos) - 1'b1);

  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && step_up && pos == PMAX) |=> pos == PMAX);

  a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && step_dn && pos == '0) |=> pos == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && (step_up == step_dn)) |=> $stable(pos));

  a_r8_recall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    recall_fire |-> src == SRC_RECALL);

  a_r9_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  a_r9_tap_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tap_sel[$past(pos)]);
endmodule

bind wiper_pos_ctrl wpc_checker #(.POS_W(POS_W)) u_wpc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .recall_fire (recall_fire),
  .src         (src),
  .recall_val  (recall_val),
  .ser_ld      (ser_ld),
  .ser_val     (ser_val),
  .par_ld      (par_ld),
  .par_val     (par_val),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .pos         (pos),
  .tap_sel     (tap_sel)
);

// File: tb/wiper_pos_ctrl_tb_top.sv
`timescale 1ns/1ps
module wiper_pos_ctrl_tb_top;
  localparam int PW = 6;
  localparam int NT = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          supply_ok;
  logic [PW-1:0] recall_val, ser_val, par_val;
  logic          ser_ld, par_ld, step_up, step_dn;
  logic [PW-1:0] pos;
  logic [NT-1:0] tap_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wiper_pos_ctrl #(.POS_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .recall_val(recall_val),
    .ser_ld(ser_ld), .ser_val(ser_val), .par_ld(par_ld), .par_val(par_val),
    .step_up(step_up), .step_dn(step_dn), .pos(pos), .tap_sel(tap_sel)
  );

  task automatic chk(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ser_ld = 0; par_ld = 0; step_up = 0; step_dn = 0;
  endtask

  // Drive inputs for one edge, then release them just after the edge.
  task automatic cycle(input logic sl, input logic [PW-1:0] sv,
                       input logic pl, input logic [PW-1:0] pv,
                       input logic up, input logic dn);
    ser_ld = sl; ser_val = sv; par_ld = pl; par_val = pv;
    step_up = up; step_dn = dn;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic do_reset();
    rst_n = 0; supply_ok = 0; recall_val = '0; ser_val = '0; par_val = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pos after reset", NT'(pos), '0);
    chk("R1 tap_sel after reset", tap_sel, NT'(1));
  endtask

  task automatic t_recall();
    recall_val = 6'h2A; supply_ok = 1;
    @(posedge clk); #1;
    chk("R2 recall load", NT'(pos), NT'(6'h2A));
    recall_val = 6'h05; supply_ok = 0;
    @(posedge clk); #1 supply_ok = 1;
    @(posedge clk); #1;
    chk("R2 recall only once", NT'(pos), NT'(6'h2A));
  endtask

  task automatic t_loads();
    cycle(1, 6'h11, 0, 6'h00, 0, 0);
    chk("R3 serial load", NT'(pos), NT'(6'h11));
    @(posedge clk); #1;
    chk("R9 tap follows pos", tap_sel, NT'(1) << 6'h11);
    cycle(0, 6'h00, 1, 6'h33, 0, 0);
    chk("R4 parallel load", NT'(pos), NT'(6'h33));
  endtask

  task automatic t_steps();
    cycle(1, 6'h20, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 0);
    chk("R5 step up", NT'(pos), NT'(6'h21));
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    chk("R5 step down twice", NT'(pos), NT'(6'h1F));
    cycle(0, 0, 0, 0, 1, 1);
    chk("R7 opposite steps cancel", NT'(pos), NT'(6'h1F));
    @(posedge clk); #1;
    chk("R7 idle holds", NT'(pos), NT'(6'h1F));
  endtask

  task automatic t_saturate();
    cycle(1, 6'h3E, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 1, 0);
    chk("R6 saturate high", NT'(pos), NT'(6'h3F));
    @(posedge clk); #1;
    chk("R9 high terminal tap", tap_sel, NT'(1) << 63);
    cycle(1, 6'h01, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);
    chk("R6 saturate low", NT'(pos), '0);
    @(posedge clk); #1;
    chk("R9 low terminal tap", tap_sel, NT'(1));
  endtask

  task automatic t_priority();
    do_reset();
    recall_val = 6'h0C; supply_ok = 1;
    cycle(1, 6'h30, 1, 6'h31, 1, 0);
    chk("R8 recall beats serial", NT'(pos), NT'(6'h0C));
    cycle(1, 6'h15, 1, 6'h2B, 0, 1);
    chk("R8 serial beats parallel", NT'(pos), NT'(6'h15));
    cycle(0, 0, 1, 6'h2B, 1, 0);
    chk("R8 parallel beats step", NT'(pos), NT'(6'h2B));
  endtask

  task automatic t_onehot_sweep();
    for (int v = 0; v < NT; v += 9) begin
      cycle(1, PW'(v), 0, 0, 0, 0);
      @(posedge clk); #1;
      chk("R9 one-hot sweep", tap_sel, NT'(1) << v);
    end
  endtask

  initial begin
    t_reset();
    t_recall();
    t_loads();
    t_steps();
    t_saturate();
    t_priority();
    t_onehot_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule